// File: doc/BRIEF.md
# Operand Bypass Selection Unit

This block is the forwarding network of a five-stage integer pipeline. For each place that consumes a register operand (the two ALU inputs in the execute stage and the store-data input in the memory stage) it decides whether the value read from the register file is still current. If a newer result for that register is still travelling down the pipe, the block uses that result instead. It produces a mux select for each consumer and also the operand value that the select picks.

Base addresses for loads and stores, and the register operand of a branch or jump, reach the execute stage through ALU input A or B. They are covered by the same two paths. There are three producer paths. The execute-to-execute path takes the ALU result held in the memory-stage register. The memory-to-execute path takes the result held in the write-back-stage register, which is either ALU output or load data. The memory-to-memory path hands a write-back-stage result, typically fresh load data, straight to a store that sits in the memory stage.

The block is purely combinational. Stall generation, the register file and the data memory are outside it. A load still in the memory stage cannot feed the execute stage, and the hazard logic must stall for that case.

Top module: `fwd_unit`

## Requirements
- R1: Every select output uses the encoding 0 = register-file value, 1 = memory-stage result, 2 = write-back-stage result. The value 3 never appears.
- R2: When a valid, non-load memory-stage instruction's destination equals an execute source, that source's select is 1 and its operand equals the memory-stage ALU result.
- R3: When the memory stage does not match an execute source but a valid write-back-stage instruction's destination does, the select is 2. The operand equals the write-back load data if that instruction is a load, and otherwise equals its ALU result.
- R4: When both the memory-stage and write-back-stage instructions match the same execute source, the memory-stage (younger) result is chosen (select 1).
- R5: A load that is in the memory stage is never forwarded to an execute source. A source matched only by it gets select 0 and the register-file value.
- R6: A destination of register 31 is never forwarded on any path, even when a source also names register 31.
- R7: A producer whose valid flag is low (a bubble) is never forwarded on any path.
- R8: When the memory-stage instruction is a store and a valid write-back-stage destination equals its store-data source, the store-data select is 2. The store data equals the load data for a load producer and the ALU result otherwise.
- R9: When the memory-stage instruction is not a store, or nothing in write-back matches, the store-data select is 0 and the store data equals the value carried in the pipeline.
- R10: An execute source with no forwarding match gets select 0 and its register-file value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | Register number feeding ALU input A |
| ex_src_b | input | 5 | Register number feeding ALU input B |
| ex_rf_a | input | 64 | Register-file value for input A |
| ex_rf_b | input | 64 | Register-file value for input B |
| mem_valid | input | 1 | Memory-stage instruction is real, not a bubble |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_dst | input | 5 | Memory-stage destination register |
| mem_alu_res | input | 64 | Memory-stage ALU result |
| mem_st_src | input | 5 | Store-data source register of the memory-stage store |
| mem_st_pipe | input | 64 | Store data carried down the pipeline |
| wb_valid | input | 1 | Write-back-stage instruction is real |
| wb_is_load | input | 1 | Write-back-stage instruction is a load |
| wb_dst | input | 5 | Write-back-stage destination register |
| wb_alu_res | input | 64 | Write-back-stage ALU result |
| wb_load_data | input | 64 | Write-back-stage load data |
| sel_a | output | 2 | Select for ALU input A |
| sel_b | output | 2 | Select for ALU input B |
| sel_st | output | 2 | Select for store data |
| op_a | output | 64 | Operand for ALU input A |
| op_b | output | 64 | Operand for ALU input B |
| st_data | output | 64 | Store data into memory |

## Verification
The bench builds the block with its default parameters: 64-bit operands, 5-bit register numbers and register 31 as the discarded destination. It walks every combination of writer class, reader field and distance 1 or 2 with distinct data patterns. Random phases then draw register numbers from a narrow range. This makes double matches, register-31 collisions, bubbles and load-versus-ALU producers frequent. The full 64-bit width lets a wrong path be told apart by its data value as well as by its select.

// File: rtl/fwd_pkg.sv
// Shared types for the operand bypass unit.
package fwd_pkg;
    // Operand origin chosen by a bypass select.
    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_MEM = 2'd1,
        SRC_WB  = 2'd2
    } fwd_src_e;
endpackage

// File: rtl/fwd_match.sv
// Decides the operand origin for one consumer register.
// Assumes producer qualifiers (valid, not-load) are already folded in.
// TAKE_MEM = 0 disables the memory-stage path for consumers at MEM.
module fwd_match
    import fwd_pkg::*;
#(
    parameter int REG_AW   = 5,
    parameter int ZERO_REG = 31,
    parameter bit TAKE_MEM = 1'b1
) (
    input  logic              use_en,
    input  logic [REG_AW-1:0] src,
    input  logic              mem_ok,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              wb_ok,
    input  logic [REG_AW-1:0] wb_dst,
    output fwd_src_e          sel
);
    localparam logic [REG_AW-1:0] ZREG = REG_AW'(ZERO_REG);

    logic mem_hit;
    logic wb_hit;

    // Compare each producer against the consumer register.
    always_comb begin
        mem_hit = TAKE_MEM && use_en && mem_ok && (mem_dst != ZREG) && (mem_dst == src);
        wb_hit  = use_en && wb_ok && (wb_dst != ZREG) && (wb_dst == src);
    end

    // Younger producer wins over older one.
    always_comb begin
        if (mem_hit)     sel = SRC_MEM;
        else if (wb_hit) sel = SRC_WB;
        else             sel = SRC_RF;
    end
endmodule

// File: rtl/fwd_mux.sv
// Three-way operand mux driven by a bypass select.
module fwd_mux
    import fwd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  fwd_src_e        sel,
    input  logic [XLEN-1:0] rf_val,
    input  logic [XLEN-1:0] mem_val,
    input  logic [XLEN-1:0] wb_val,
    output logic [XLEN-1:0] out
);
    // Pick the operand named by the select.
    always_comb begin
        unique case (sel)
            SRC_MEM: out = mem_val;
            SRC_WB:  out = wb_val;
            default: out = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
// Operand bypass selection for a five-stage integer pipeline.
// Serves ALU inputs A/B in EX and store data in MEM. A load in MEM
// is never forwarded; load-use stalls are the hazard unit's job.
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int REG_AW   = 5,
    parameter int ZERO_REG = 31
) (
    input  logic [REG_AW-1:0] ex_src_a,
    input  logic [REG_AW-1:0] ex_src_b,
    input  logic [XLEN-1:0]   ex_rf_a,
    input  logic [XLEN-1:0]   ex_rf_b,
    input  logic              mem_valid,
    input  logic              mem_is_load,
    input  logic              mem_is_store,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic [XLEN-1:0]   mem_alu_res,
    input  logic [REG_AW-1:0] mem_st_src,
    input  logic [XLEN-1:0]   mem_st_pipe,
    input  logic              wb_valid,
    input  logic              wb_is_load,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic [XLEN-1:0]   wb_alu_res,
    input  logic [XLEN-1:0]   wb_load_data,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [1:0]        sel_st,
    output logic [XLEN-1:0]   op_a,
    output logic [XLEN-1:0]   op_b,
    output logic [XLEN-1:0]   st_data
);
    localparam int N_EX = 2;

    logic            mem_ok;
    logic [XLEN-1:0] wb_val;
    logic [REG_AW-1:0] ex_src [N_EX];
    logic [XLEN-1:0]   ex_rf  [N_EX];
    fwd_src_e          ex_sel [N_EX];
    logic [XLEN-1:0]   ex_op  [N_EX];
    fwd_src_e          st_sel;

    // Qualify the MEM producer and form the WB result.
    always_comb begin
        mem_ok = mem_valid && !mem_is_load;
        wb_val = wb_is_load ? wb_load_data : wb_alu_res;
    end

    // Gather EX consumers into arrays.
    always_comb begin
        ex_src[0] = ex_src_a;
        ex_src[1] = ex_src_b;
        ex_rf[0]  = ex_rf_a;
        ex_rf[1]  = ex_rf_b;
    end

    for (genvar g = 0; g < N_EX; g++) begin : g_ex
        fwd_match #(.REG_AW(REG_AW), .ZERO_REG(ZERO_REG), .TAKE_MEM(1'b1)) u_match (
            .use_en  (1'b1),
            .src     (ex_src[g]),
            .mem_ok  (mem_ok),
            .mem_dst (mem_dst),
            .wb_ok   (wb_valid),
            .wb_dst  (wb_dst),
            .sel     (ex_sel[g])
        );
        fwd_mux #(.XLEN(XLEN)) u_mux (
            .sel     (ex_sel[g]),
            .rf_val  (ex_rf[g]),
            .mem_val (mem_alu_res),
            .wb_val  (wb_val),
            .out     (ex_op[g])
        );
    end

    fwd_match #(.REG_AW(REG_AW), .ZERO_REG(ZERO_REG), .TAKE_MEM(1'b0)) u_st_match (
        .use_en  (mem_is_store),
        .src     (mem_st_src),
        .mem_ok  (mem_ok),
        .mem_dst (mem_dst),
        .wb_ok   (wb_valid),
        .wb_dst  (wb_dst),
        .sel     (st_sel)
    );
    fwd_mux #(.XLEN(XLEN)) u_st_mux (
        .sel     (st_sel),
        .rf_val  (mem_st_pipe),
        .mem_val (mem_alu_res),
        .wb_val  (wb_val),
        .out     (st_data)
    );

    // Drive the output ports.
    always_comb begin
        sel_a  = ex_sel[0];
        sel_b  = ex_sel[1];
        sel_st = st_sel;
        op_a   = ex_op[0];
        op_b   = ex_op[1];
    end
endmodule

// File: rtl/fwd_unit_chk.sv
// Port-level checks for fwd_unit; combinational block, so immediate
// assertions evaluated whenever the inputs settle.
module fwd_unit_chk #(
    parameter int XLEN     = 64,
    parameter int REG_AW   = 5,
    parameter int ZERO_REG = 31
) (
    input logic [REG_AW-1:0] ex_src_a,
    input logic [XLEN-1:0]   ex_rf_a,
    input logic              mem_valid,
    input logic              mem_is_load,
    input logic              mem_is_store,
    input logic [REG_AW-1:0] mem_dst,
    input logic [XLEN-1:0]   mem_alu_res,
    input logic [XLEN-1:0]   mem_st_pipe,
    input logic              wb_valid,
    input logic [REG_AW-1:0] wb_dst,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [1:0]        sel_st,
    input logic [XLEN-1:0]   op_a,
    input logic [XLEN-1:0]   st_data
);
    localparam logic [REG_AW-1:0] ZREG = REG_AW'(ZERO_REG);

    // Check port relations on every input change.
    always_comb begin
        a_r1_sel_legal: assert (sel_a != 2'd3 && sel_b != 2'd3 && sel_st != 2'd3)
            else $error("select value 3 seen");
        if (sel_a == 2'd1) begin
            a_r2_mem_value: assert (op_a == mem_alu_res)
                else $error("op_a differs from MEM result");
            a_r5_no_mem_load: assert (mem_valid && !mem_is_load)
                else $error("MEM path used by load or bubble");
            a_r6_mem_not_r31: assert (mem_dst != ZREG && mem_dst == ex_src_a)
                else $error("MEM path from r31 or mismatch");
        end
        if (sel_a == 2'd0) begin
            a_r10_rf_value: assert (op_a == ex_rf_a)
                else $error("op_a differs from register file");
        end
        if (sel_a == 2'd2 || sel_st == 2'd2) begin
            a_r7_wb_valid: assert (wb_valid && wb_dst != ZREG)
                else $error("WB path from bubble or r31");
        end
        if (!mem_is_store) begin
            a_r9_no_store_pass: assert (sel_st == 2'd0 && st_data == mem_st_pipe)
                else $error("store path active without a store");
        end
    end
endmodule

bind fwd_unit fwd_unit_chk #(.XLEN(XLEN), .REG_AW(REG_AW), .ZERO_REG(ZERO_REG)) u_chk (
    .ex_src_a     (ex_src_a),
    .ex_rf_a      (ex_rf_a),
    .mem_valid    (mem_valid),
    .mem_is_load  (mem_is_load),
    .mem_is_store (mem_is_store),
    .mem_dst      (mem_dst),
    .mem_alu_res  (mem_alu_res),
    .mem_st_pipe  (mem_st_pipe),
    .wb_valid     (wb_valid),
    .wb_dst       (wb_dst),
    .sel_a        (sel_a),
    .sel_b        (sel_b),
    .sel_st       (sel_st),
    .op_a         (op_a),
    .st_data      (st_data)
);

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
    localparam int XLEN = 64;
    localparam int AW   = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [AW-1:0]   ex_src_a, ex_src_b, mem_dst, mem_st_src, wb_dst;
    logic [XLEN-1:0] ex_rf_a, ex_rf_b, mem_alu_res, mem_st_pipe, wb_alu_res, wb_load_data;
    logic mem_valid, mem_is_load, mem_is_store, wb_valid, wb_is_load;
    logic [1:0] sel_a, sel_b, sel_st;
    logic [XLEN-1:0] op_a, op_b, st_data;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    fwd_unit u_fwd_unit (
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
        .mem_valid(mem_valid), .mem_is_load(mem_is_load), .mem_is_store(mem_is_store),
        .mem_dst(mem_dst), .mem_alu_res(mem_alu_res), .mem_st_src(mem_st_src),
        .mem_st_pipe(mem_st_pipe), .wb_valid(wb_valid), .wb_is_load(wb_is_load),
        .wb_dst(wb_dst), .wb_alu_res(wb_alu_res), .wb_load_data(wb_load_data),
        .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st),
        .op_a(op_a), .op_b(op_b), .st_data(st_data)
    );

    // Reference select for an EX source (R2..R7, R10).
    function automatic logic [1:0] ref_ex(input logic [AW-1:0] s);
        if (mem_valid && !mem_is_load && mem_dst != 5'd31 && mem_dst == s) return 2'd1;
        if (wb_valid && wb_dst != 5'd31 && wb_dst == s) return 2'd2;
        return 2'd0;
    endfunction

    // Reference select for store data (R8, R9).
    function automatic logic [1:0] ref_st();
        if (mem_is_store && wb_valid && wb_dst != 5'd31 && wb_dst == mem_st_src) return 2'd2;
        return 2'd0;
    endfunction

    function automatic logic [XLEN-1:0] ref_val(input logic [1:0] s, input logic [XLEN-1:0] rf);
        if (s == 2'd1) return mem_alu_res;
        if (s == 2'd2) return wb_is_load ? wb_load_data : wb_alu_res;
        return rf;
    endfunction

    function automatic string tag_of(input logic [1:0] s, input bit st);
        if (st) return (s == 2'd2) ? "R8" : "R9";
        if (s == 2'd1) return "R2";
        if (s == 2'd2) return "R3";
        return "R10";
    endfunction

    task automatic chk(input string tag, input string what, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Sample all outputs at the falling edge; tag "" picks a tag by outcome.
    task automatic check_all(input string tag);
        logic [1:0] ea, eb, es;
        @(negedge clk);
        ea = ref_ex(ex_src_a);
        eb = ref_ex(ex_src_b);
        es = ref_st();
        chk(tag == "" ? tag_of(ea, 0) : tag, "sel_a", XLEN'(sel_a), XLEN'(ea));
        chk(tag == "" ? tag_of(ea, 0) : tag, "op_a", op_a, ref_val(ea, ex_rf_a));
        chk(tag == "" ? tag_of(eb, 0) : tag, "sel_b", XLEN'(sel_b), XLEN'(eb));
        chk(tag == "" ? tag_of(eb, 0) : tag, "op_b", op_b, ref_val(eb, ex_rf_b));
        chk(tag == "" ? tag_of(es, 1) : tag, "sel_st", XLEN'(sel_st), XLEN'(es));
        chk(tag == "" ? tag_of(es, 1) : tag, "st_data", st_data, ref_val(es, mem_st_pipe));
        chk("R1", "sel_code", XLEN'((sel_a == 2'd3) || (sel_b == 2'd3) || (sel_st == 2'd3)), '0);
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        ex_src_a = 5'd1; ex_src_b = 5'd2; mem_dst = 5'd3; mem_st_src = 5'd4; wb_dst = 5'd5;
        ex_rf_a = 64'hAAAA_0000_0000_0001; ex_rf_b = 64'hBBBB_0000_0000_0002;
        mem_alu_res = 64'h1111_2222_3333_4444; mem_st_pipe = 64'h5555_6666_7777_8888;
        wb_alu_res = 64'h9999_AAAA_BBBB_CCCC; wb_load_data = 64'hDDDD_EEEE_FFFF_0001;
        mem_valid = 0; mem_is_load = 0; mem_is_store = 0; wb_valid = 0; wb_is_load = 0;
    endtask

    function automatic logic [XLEN-1:0] r64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        void'($urandom(32'd1234));
        idle();
        #1;
        check_all("R10");   // all bubbles: register-file values everywhere

        // Writer class x reader field x distance enumeration.
        for (int w = 0; w < 2; w++) begin          // 0 = ALU writer, 1 = load writer
            for (int d = 1; d <= 2; d++) begin     // distance
                for (int r = 0; r < 3; r++) begin  // 0 = A, 1 = B, 2 = store data
                    idle();
                    ex_rf_a = r64(); ex_rf_b = r64(); mem_alu_res = r64();
                    wb_alu_res = r64(); wb_load_data = r64(); mem_st_pipe = r64();
                    if (r == 0) ex_src_a = 5'd7;
                    if (r == 1) ex_src_b = 5'd7;
                    if (r == 2) begin mem_is_store = 1; mem_valid = 1; mem_st_src = 5'd7; end
                    if (d == 1) begin
                        mem_valid = 1; mem_is_load = (w == 1); mem_dst = 5'd7;
                        mem_is_store = (r == 2) && (w == 0) ? 1'b0 : mem_is_store;
                    end else begin
                        wb_valid = 1; wb_is_load = (w == 1); wb_dst = 5'd7;
                    end
                    // d1 load -> R5; d1 ALU -> R2; d2 -> R3 or R8
                    check_all("");
                end
            end
        end

        // R4: both stages match, younger wins.
        idle(); ex_src_a = 5'd9; ex_src_b = 5'd9;
        mem_valid = 1; mem_dst = 5'd9; wb_valid = 1; wb_dst = 5'd9;
        check_all("R4");
        // R5: load in MEM with older ALU match in WB -> WB chosen.
        mem_is_load = 1;
        check_all("R5");
        // R6: register 31 everywhere.
        idle(); ex_src_a = 5'd31; ex_src_b = 5'd31; mem_st_src = 5'd31; mem_is_store = 1;
        mem_valid = 1; mem_dst = 5'd31; wb_valid = 1; wb_dst = 5'd31;
        check_all("R6");
        // R7: bubbles carrying matching destinations.
        idle(); ex_src_a = 5'd12; mem_dst = 5'd12; wb_dst = 5'd12;
        mem_is_store = 1; mem_st_src = 5'd12;
        check_all("R7");
        // R8: load data into following store (memory-to-memory).
        idle(); mem_valid = 1; mem_is_store = 1; mem_st_src = 5'd14;
        wb_valid = 1; wb_is_load = 1; wb_dst = 5'd14;
        check_all("R8");
        // R9: matching WB but MEM is not a store.
        mem_is_store = 0;
        check_all("R9");

        // Random phase with narrow register range.
        for (int i = 0; i < 3000; i++) begin
            ex_src_a = AW'($urandom_range(0, 3)) | ((($urandom & 3) == 0) ? 5'd31 : 5'd0);
            ex_src_b = AW'($urandom_range(0, 3));
            mem_dst = ($urandom_range(0, 7) == 0) ? 5'd31 : AW'($urandom_range(0, 3));
            wb_dst  = ($urandom_range(0, 7) == 0) ? 5'd31 : AW'($urandom_range(0, 3));
            mem_st_src = AW'($urandom_range(0, 3));
            mem_valid = 1'($urandom); mem_is_load = 1'($urandom);
            mem_is_store = !mem_is_load && 1'($urandom);
            wb_valid = 1'($urandom); wb_is_load = 1'($urandom);
            ex_rf_a = r64(); ex_rf_b = r64(); mem_alu_res = r64(); mem_st_pipe = r64();
            wb_alu_res = r64(); wb_load_data = r64();
            check_all("");
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_errs++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule